// File: doc/BRIEF.md
# Serially Configured Six-Way Clock Gate

This block gates six copies of one clock input. Each copy has its own enable bit. The enable bits sit in three 8-bit configuration registers. A host loads those registers through a two-wire serial bus. The block acts only as a receiver on that bus. It runs from a fast system clock and samples the serial clock and serial data lines through synchronizers. It finds the start and stop conditions, checks the slave address, and pulls the data line low to acknowledge each byte.

A host transaction is a block write with the following order:
1. The address byte, with the direction bit set for a write.
2. A command byte.
3. A count byte.
4. Any number of data bytes.

The block acknowledges the command and count bytes and then discards them. Data bytes fill register 0, then register 1, then register 2. Data bytes beyond register 2 are acknowledged and dropped. A stop may end the transfer after any whole byte. Output enables change only while the clock input is low, so a gated output never shows a shortened pulse.

Top module: `serclk_fanout_ctl`

## Requirements
- R1: After reset all three registers read 0xFF, so all six outputs follow `clk_in`.
- R2: The block acknowledges the address byte 0xD2 (address 1101001, direction bit 0) by driving `sda_oe` high through the ninth clock of that byte.
- R3: An address byte with another address, or with the direction bit set to 1 (0xD3), gets no acknowledge. The block then ignores the bus until the next start condition, and no register changes.
- R4: The command byte and the count byte are both acknowledged. Their values never change any register.
- R5: Data bytes arrive most significant bit first and are written in order to registers 0, 1 and 2. Output bits map to register bits as follows: `clk_out[0]` = reg0 bit 0, `clk_out[1]` = reg0 bit 2, `clk_out[2]` = reg0 bit 7, `clk_out[3]` = reg1 bit 3, `clk_out[4]` = reg1 bit 6, `clk_out[5]` = reg2 bit 7.
- R6: A stop after fewer than three data bytes leaves the registers that were not reached unchanged.
- R7: Data bytes past register 2 are acknowledged and do not change any register.
- R8: An output whose enable bit is 1 equals `clk_in`. An output whose enable bit is 0 stays low.
- R9: A new enable value takes effect only while `clk_in` is low. While `clk_in` stays high, no output changes.
- R10: A start condition in the middle of a transfer (a repeated start) restarts address reception, including after a rejected address.
- R11: The block drives `sda_oe` only during acknowledge bits, and it starts or stops driving only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock. Much faster than SCL. |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND of the bus) |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| clk_in | input | 1 | Clock to be distributed |
| clk_out | output | 6 | Gated copies of `clk_in` |

## Verification
The assertions assume the following about the inputs:
- SCL is much slower than the system clock.
- The host changes SDA only while SCL is low, except to form start and stop conditions.
- `clk_in` changes away from system clock edges.

The bench keeps to these rules. Its bus tasks use a quarter-bit time of eight system clocks and change SDA only in the low phase of SCL. It models the line as the wired-AND of host and slave. It holds `clk_in` steady during each transfer and changes it only between checks.

// File: rtl/fanout_pkg.sv
// Shared constants and types for the serially configured clock gate.
// Assumes one bus slave address and a fixed output-to-register-bit map.
package fanout_pkg;
    localparam int NUM_OUT  = 6;
    localparam int NUM_REG  = 3;
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 6;
    localparam int IDX_W    = (NUM_REG > 1) ? $clog2(NUM_REG) : 1;
    localparam logic [6:0] SLAVE_ADDR = 7'b1101001;

    // Register and bit that enable each output.
    localparam int OUT_REG [NUM_OUT] = '{0, 0, 0, 1, 1, 2};
    localparam int OUT_BIT [NUM_OUT] = '{0, 2, 7, 3, 6, 7};

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_BITS = 2'd1,
        RX_ACKW = 2'd2,
        RX_ACK  = 2'd3
    } rx_state_t;
endpackage

// File: rtl/fanout_line_sync.sv
// Synchronizes SCL and SDA into the system clock domain and produces
// one-cycle event strobes: SCL rising, SCL falling, start and stop.
// Assumes the system clock is much faster than SCL.
module fanout_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_bit
);
    logic [1:0] scl_ff, sda_ff;
    logic       scl_q, sda_q;

    // Two-flop synchronizers plus one history stage; the bus idles high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= 2'b11;
            sda_ff <= 2'b11;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[0], scl_i};
            sda_ff <= {sda_ff[0], sda_i};
            scl_q  <= scl_ff[1];
            sda_q  <= sda_ff[1];
        end
    end

    // Decode events from the current and previous synchronized levels.
    always_comb begin
        scl_rise  = !scl_q && scl_ff[1];
        scl_fall  = scl_q && !scl_ff[1];
        start_det = scl_q && scl_ff[1] && sda_q && !sda_ff[1];
        stop_det  = scl_q && scl_ff[1] && !sda_q && sda_ff[1];
        sda_bit   = sda_ff[1];
    end
endmodule

// File: rtl/fanout_smbus_rx.sv
// Write-only serial receiver. It matches the address, acknowledges bytes,
// skips the command and count bytes, and issues a register write for each
// data byte that fits. Assumes the host changes SDA only while SCL is low,
// except to form start and stop conditions.
module fanout_smbus_rx
    import fanout_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_bit,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data
);
    localparam logic [CNT_W-1:0] HDR_BYTES = CNT_W'(2);
    localparam logic [CNT_W-1:0] CNT_MAX   = '1;

    rx_state_t         state;
    logic [2:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  byte_cnt;
    logic              is_addr;
    logic [CNT_W-1:0]  data_pos;
    logic              data_fits;

    // Position of the current byte after the command and count bytes.
    always_comb begin
        data_pos  = byte_cnt - HDR_BYTES;
        data_fits = (byte_cnt >= HDR_BYTES) && (data_pos < CNT_W'(NUM_REG));
    end

    // Receiver state machine, advanced by the bus events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            byte_cnt <= '0;
            is_addr  <= 1'b0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state    <= RX_BITS;
                bit_cnt  <= '0;
                byte_cnt <= '0;
                is_addr  <= 1'b1;
                sda_oe   <= 1'b0;
            end else if (stop_det) begin
                state  <= RX_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    RX_IDLE: ;
                    RX_BITS: if (scl_rise) begin
                        shreg   <= {shreg[BYTE_W-2:0], sda_bit};
                        bit_cnt <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7) state <= RX_ACKW;
                    end
                    RX_ACKW: if (scl_fall) begin
                        if (is_addr && shreg != {SLAVE_ADDR, 1'b0}) begin
                            state <= RX_IDLE;
                        end else begin
                            sda_oe <= 1'b1;
                            state  <= RX_ACK;
                            if (!is_addr && data_fits) begin
                                wr_en   <= 1'b1;
                                wr_idx  <= IDX_W'(data_pos);
                                wr_data <= shreg;
                            end
                        end
                    end
                    RX_ACK: if (scl_fall) begin
                        sda_oe  <= 1'b0;
                        state   <= RX_BITS;
                        is_addr <= 1'b0;
                        if (!is_addr && byte_cnt != CNT_MAX)
                            byte_cnt <= byte_cnt + CNT_W'(1);
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/fanout_cfg_gate.sv
// Configuration register bank and output gates. Each output follows
// clk_in when its enable bit is set. The enable copy used by the gates
// changes only while clk_in is low. Assumes clk_in is slower than clk.
module fanout_cfg_gate
    import fanout_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [BYTE_W-1:0]  wr_data,
    input  logic               clk_in,
    output logic [NUM_OUT-1:0] clk_out
);
    logic [BYTE_W-1:0]  cfg [NUM_REG];
    logic [NUM_OUT-1:0] en_sel;
    logic [NUM_OUT-1:0] en_q;

    // Register bank: reset to all ones, write one register per strobe.
    always_ff @(posedge clk) begin
        for (int r = 0; r < NUM_REG; r++) begin
            if (!rst_n)
                cfg[r] <= '1;
            else if (wr_en && wr_idx == IDX_W'(r))
                cfg[r] <= wr_data;
        end
    end

    // Pick each output's enable bit from the map in the package.
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        assign en_sel[g]  = cfg[OUT_REG[g]][OUT_BIT[g]];
        assign clk_out[g] = clk_in & en_q[g];
    end

    // Copy enables into the gates only while clk_in is low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '1;
        else if (!clk_in)
            en_q <= en_sel;
    end
endmodule

// File: rtl/serclk_fanout_ctl.sv
// Top level: line synchronizer, block-write receiver, and the
// configuration and gating stage. sda_oe means "pull SDA low".
module serclk_fanout_ctl
    import fanout_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic               clk_in,
    output logic [NUM_OUT-1:0] clk_out
);
    logic              scl_rise, scl_fall, start_det, stop_det, sda_bit;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;

    fanout_line_sync i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_bit   (sda_bit)
    );

    fanout_smbus_rx i_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_bit   (sda_bit),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    fanout_cfg_gate i_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .clk_in  (clk_in),
        .clk_out (clk_out)
    );
endmodule

// File: rtl/serclk_fanout_chk.sv
// Port-level properties of the clock gate. It is bound to every instance
// of the top module.
module serclk_fanout_chk
    import fanout_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               scl_i,
    input logic               sda_oe,
    input logic               clk_in,
    input logic [NUM_OUT-1:0] clk_out
);
    // R1: the first cycle out of reset has every output enabled.
    assert_reset_all_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> clk_out == {NUM_OUT{clk_in}});

    // R8: no output is ever high while clk_in is low.
    assert_low_when_input_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_in |-> clk_out == '0);

    // R9: while clk_in stays high, the outputs hold their values.
    assert_no_change_in_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_in && $past(clk_in) && $past(rst_n)) |-> $stable(clk_out));

    // R11: the acknowledge drive starts only while SCL is low.
    assert_ack_start_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R11: the acknowledge drive is released only while SCL is low or at a start or stop.
    assert_ack_end_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_oe) && $past(rst_n)) |-> (!scl_i || $past(!scl_i, 3)));
endmodule

bind serclk_fanout_ctl serclk_fanout_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .sda_oe  (sda_oe),
    .clk_in  (clk_in),
    .clk_out (clk_out)
);

// File: tb/test_serclk_fanout_ctl.sv
// Directed bench: one task per scenario, each checking its own results.
module test_serclk_fanout_ctl;
    localparam int Q = 8;  // quarter bit time in system clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic       clk_in = 1'b0;
    logic [5:0] clk_out;
    wire        sda_line = sda_m & ~sda_oe;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] r0, r1, r2;  // expected register contents

    always #10 clk = ~clk;  // 50 MHz

    serclk_fanout_ctl i_serclk_fanout_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .clk_in  (clk_in),
        .clk_out (clk_out)
    );

    function automatic logic [5:0] exp_en();
        return {r2[7], r1[6], r1[3], r0[7], r0[2], r0[0]};
    endfunction

    task automatic cmp(input string req, input logic [7:0] act, input logic [7:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        sda_m = 1'b0; wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl = 1'b1;   wq(Q);
        sda_m = 1'b1; wq(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q);
            scl = 1'b1;   wq(2 * Q);
            scl = 1'b0;   wq(Q);
        end
        sda_m = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        ack = !sda_line;
        wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    // Show the enables at the outputs by holding clk_in high.
    task automatic observe(input string req);
        clk_in = 1'b1; wq(4);
        cmp(req, {2'b00, clk_out}, {2'b00, exp_en()});
        clk_in = 1'b0; wq(4);
    endtask

    task automatic t_reset();
        r0 = 8'hFF; r1 = 8'hFF; r2 = 8'hFF;
        clk_in = 1'b1; wq(4);
        cmp("R1 all outputs follow clk_in", {2'b00, clk_out}, 8'h3F);
        clk_in = 1'b0; wq(4);
        cmp("R8 outputs low while clk_in low", {2'b00, clk_out}, 8'h00);
        cmp("R11 no drive at idle", {7'b0, sda_oe}, 8'h00);
    endtask

    task automatic t_full_write();
        logic a;
        bus_start();
        send_byte(8'hD2, a); cmp("R2 address ack", {7'b0, a}, 8'h01);
        send_byte(8'h00, a); cmp("R4 command ack", {7'b0, a}, 8'h01);
        send_byte(8'h03, a); cmp("R4 count ack", {7'b0, a}, 8'h01);
        send_byte(8'h04, a); cmp("R5 data0 ack", {7'b0, a}, 8'h01);
        send_byte(8'h08, a); cmp("R5 data1 ack", {7'b0, a}, 8'h01);
        send_byte(8'h00, a); cmp("R5 data2 ack", {7'b0, a}, 8'h01);
        bus_stop();
        r0 = 8'h04; r1 = 8'h08; r2 = 8'h00;
        observe("R5 ordered fill and bit map");
        cmp("R11 released after stop", {7'b0, sda_oe}, 8'h00);
    endtask

    task automatic t_header_only();
        logic a;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'hFF, a); cmp("R4 nonzero command ack", {7'b0, a}, 8'h01);
        send_byte(8'hFF, a); cmp("R4 count ack", {7'b0, a}, 8'h01);
        bus_stop();
        observe("R4 header bytes leave registers");
    endtask

    task automatic t_partial();
        logic a;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        send_byte(8'h01, a);
        send_byte(8'h81, a);
        bus_stop();
        r0 = 8'h81;
        observe("R6 stop after one byte keeps reg1 reg2");
    endtask

    task automatic t_overflow();
        logic a;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        send_byte(8'h05, a);
        send_byte(8'hFF, a);
        send_byte(8'hFF, a);
        send_byte(8'hFF, a);
        send_byte(8'h00, a); cmp("R7 extra byte ack", {7'b0, a}, 8'h01);
        send_byte(8'h00, a); cmp("R7 second extra ack", {7'b0, a}, 8'h01);
        bus_stop();
        r0 = 8'hFF; r1 = 8'hFF; r2 = 8'hFF;
        observe("R7 extra bytes dropped");
    endtask

    task automatic t_bad_addr();
        logic a;
        bus_start();
        send_byte(8'h52, a); cmp("R3 wrong address nack", {7'b0, a}, 8'h00);
        send_byte(8'h00, a); cmp("R3 ignored byte nack", {7'b0, a}, 8'h00);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        bus_stop();
        bus_start();
        send_byte(8'hD3, a); cmp("R3 read direction nack", {7'b0, a}, 8'h00);
        send_byte(8'h00, a);
        bus_stop();
        observe("R3 registers unchanged");
    endtask

    task automatic t_restart();
        logic a;
        bus_start();
        send_byte(8'h22, a); cmp("R10 first address nack", {7'b0, a}, 8'h00);
        bus_start();
        send_byte(8'hD2, a); cmp("R10 address after restart ack", {7'b0, a}, 8'h01);
        send_byte(8'h00, a);
        send_byte(8'h01, a);
        send_byte(8'h00, a);
        bus_stop();
        r0 = 8'h00;
        observe("R10 write after repeated start");
    endtask

    task automatic t_glitch_free();
        logic a;
        clk_in = 1'b1; wq(2);
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        send_byte(8'h01, a);
        send_byte(8'h85, a);
        bus_stop();
        cmp("R9 outputs held while clk_in high", {2'b00, clk_out}, 8'h38);
        clk_in = 1'b0; wq(4);
        cmp("R8 all low with clk_in low", {2'b00, clk_out}, 8'h00);
        r0 = 8'h85;
        clk_in = 1'b1; wq(4);
        cmp("R9 new enables after low phase", {2'b00, clk_out}, {2'b00, exp_en()});
        clk_in = 1'b0; wq(4);
    endtask

    task automatic t_disabled_low();
        logic a;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        send_byte(8'h02, a);
        send_byte(8'h00, a);
        send_byte(8'h40, a);
        bus_stop();
        r0 = 8'h00; r1 = 8'h40;
        observe("R8 only enabled output follows");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        wq(5);
        rst_n = 1'b1;
        wq(3);
        t_reset();
        t_full_write();
        t_header_only();
        t_partial();
        t_overflow();
        t_bad_addr();
        t_restart();
        t_glitch_free();
        t_disabled_low();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule